// File: doc/BRIEF.md
# Dual-Channel Memory Stream Splitter and Merger

This block connects one host write stream to two independent memory channels, and the returning data from both channels to a single stream for a processing array. Host words are dealt out one by one to the two channels, so even-numbered words land in channel 0 and odd-numbered words in channel 1. Each channel has its own write queue, which drains into the channel's write port at whatever pace that channel accepts data.

On the read side, each channel asks for data through a simple request port and returns it through a response port. The returned words fill a per-channel read queue at the channel's own rate. The merger pops both read queues in the same cycle and emits one word of twice the width, so the processing array sees one synchronous stream in the original host order. The host side and the two channels are decoupled only by these queues. Here all queues run on one clock, with an independent push side each.

A channel raises a read request only while its read queue has room for every word already requested, so a response never finds its queue full and no returned word is lost.

Top module: `dual_lane_stream_merge`

## Requirements
- R1: After reset, the k-th host word accepted (counting from 0) is queued for channel k mod 2, and channel c's write port (`memWrData[c]`) presents its words in acceptance order.
- R2: `memWrValid[c]` is high exactly while channel c's write queue holds at least one word, and a word leaves that queue on a cycle with `memWrValid[c]` and `memWrReady[c]` both high.
- R3: `hostReady` is low exactly while the write queue of the channel whose turn it is holds DEPTH words. A stalled host word waits for that channel and never goes to the other one.
- R4: `memRdReqValid[c]` is high exactly while the words in channel c's read queue plus the requests accepted and not yet answered number fewer than DEPTH, and every response on `memRspValid[c]` is stored.
- R5: `outValid` is high exactly while both read queues are non-empty. One word leaves each queue on a cycle with `outValid` and `outReady` both high, and a queue is never popped alone.
- R6: `outData` carries the channel 1 head word in bits [2W-1:W] and the channel 0 head word in bits [W-1:0], so the n-th merged word holds host words 2n+1 (high half) and 2n (low half).
- R7: While `outValid` is high and `outReady` low, `outData` and `outValid` hold their values into the next cycle.
- R8: Synchronous active-low reset empties all four queues, clears the unanswered-request counts and points the dispatcher at channel 0. Right after reset, `hostReady` is 1, `outValid` is 0, `memWrValid` is 2'b00 and `memRdReqValid` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Synchronous active-low reset |
| hostValid | input | 1 | Host offers a word |
| hostData | input | DATA_W | Host word |
| hostReady | output | 1 | Host word is taken this cycle when valid |
| memWrValid | output | 2 | Per-channel write word available |
| memWrData | output | 2 x DATA_W | Per-channel write word, index 0 is channel 0 |
| memWrReady | input | 2 | Per-channel write acceptance |
| memRdReqValid | output | 2 | Per-channel read request |
| memRdReqReady | input | 2 | Per-channel read request accepted |
| memRspValid | input | 2 | Per-channel read data returned |
| memRspData | input | 2 x DATA_W | Per-channel returned read word |
| outValid | output | 1 | Merged word available |
| outData | output | 2 x DATA_W | Merged word {channel 1, channel 0} |
| outReady | input | 1 | Processing array takes the merged word |

## Verification
The bench runs the block with balanced random traffic, with a nearly stalled output while the host pushes every cycle, with channel 1 answering reads far more slowly than channel 0, and with a reset landing while words are in flight. The output stall fills every queue and separates a dispatcher that stalls correctly from one that skips to the other channel or overwrites a full queue. The lopsided channel rates separate a merger that waits for both queues from one that pops a single queue, and show whether the request credit stops requests before the slow queue overflows. A model built from queues predicts every port on every cycle, and each merged word is compared with the host word sequence to confirm the order.

// File: rtl/dlsm_pkg.sv
package dlsm_pkg;
  // Strobes from the control to the datapath, one bit per lane where split.
  typedef struct packed {
    logic [1:0] wrPush;   // host word enters lane write queue
    logic [1:0] wrPop;    // lane write queue head taken by channel
    logic [1:0] rspPush;  // channel response enters lane read queue
    logic       popBoth;  // both read queues advance together
  } dlsmStrobes_t;
endpackage

// File: rtl/dlsm_fifo.sv
module dlsm_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [CW-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  assign popData = store[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0)); // R5
endmodule

// File: rtl/dlsm_datapath.sv
module dlsm_datapath
  import dlsm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dlsmStrobes_t               st,
  input  logic [DATA_W-1:0]          hostData,
  input  logic [1:0][DATA_W-1:0]     rspData,
  output logic [1:0][DATA_W-1:0]     wrData,
  output logic [2*DATA_W-1:0]        outData,
  output logic [1:0]                 wrFull,
  output logic [1:0]                 wrEmpty,
  output logic [1:0]                 rdEmpty,
  output logic [1:0][CW-1:0]         rdCount
);
  logic [1:0][CW-1:0]     wrCount;
  logic [1:0][DATA_W-1:0] rdHead;

  for (genvar g = 0; g < 2; g++) begin : gLane
    dlsm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uWrQ (
      .clk(clk), .rstN(rstN),
      .push(st.wrPush[g]), .pushData(hostData),
      .pop(st.wrPop[g]), .popData(wrData[g]),
      .count(wrCount[g])
    );
    dlsm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uRdQ (
      .clk(clk), .rstN(rstN),
      .push(st.rspPush[g]), .pushData(rspData[g]),
      .pop(st.popBoth), .popData(rdHead[g]),
      .count(rdCount[g])
    );
    assign wrFull[g]  = (wrCount[g] == CW'(DEPTH));
    assign wrEmpty[g] = (wrCount[g] == '0);
    assign rdEmpty[g] = (rdCount[g] == '0);
  end

  assign outData = {rdHead[1], rdHead[0]};

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.wrPush)); // R1
  AST_PAIR_POP: assert property (@(posedge clk) disable iff (!rstN)
    st.popBoth |-> (!rdEmpty[0] && !rdEmpty[1])); // R5
endmodule

// File: rtl/dlsm_ctrl.sv
module dlsm_ctrl
  import dlsm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  output logic               hostReady,
  input  logic [1:0]         wrFull,
  input  logic [1:0]         wrEmpty,
  input  logic [1:0]         memWrReady,
  output logic [1:0]         memWrValid,
  input  logic [1:0][CW-1:0] rdCount,
  input  logic [1:0]         rdEmpty,
  input  logic [1:0]         memRdReqReady,
  output logic [1:0]         memRdReqValid,
  input  logic [1:0]         memRspValid,
  input  logic               outReady,
  output logic               outValid,
  output dlsmStrobes_t       st
);
  localparam int SW = CW + 1;

  logic laneSel;
  logic hostFire;

  assign hostReady  = !wrFull[laneSel];
  assign hostFire   = hostValid && hostReady;
  assign memWrValid = ~wrEmpty;
  assign outValid   = !rdEmpty[0] && !rdEmpty[1];

  always_comb begin
    st.wrPush  = hostFire ? (laneSel ? 2'b10 : 2'b01) : 2'b00;
    st.wrPop   = memWrValid & memWrReady;
    st.rspPush = memRspValid;
    st.popBoth = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         laneSel <= 1'b0;
    else if (hostFire) laneSel <= ~laneSel;
  end

  for (genvar g = 0; g < 2; g++) begin : gCredit
    logic [CW-1:0] inFlight;
    logic [SW-1:0] claimed;
    logic          reqFire;

    assign claimed           = {1'b0, rdCount[g]} + {1'b0, inFlight};
    assign memRdReqValid[g]  = (claimed < SW'(DEPTH));
    assign reqFire           = memRdReqValid[g] && memRdReqReady[g];

    always_ff @(posedge clk) begin
      if (!rstN) inFlight <= '0;
      else       inFlight <= inFlight + CW'(reqFire) - CW'(memRspValid[g]);
    end

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rstN)
      claimed <= SW'(DEPTH)); // R4
  end

  AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    hostFire |=> (laneSel != $past(laneSel))); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostReady) |=> (laneSel == $past(laneSel))); // R3
endmodule

// File: rtl/dual_lane_stream_merge.sv
module dual_lane_stream_merge
  import dlsm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostValid,
  input  logic [DATA_W-1:0]      hostData,
  output logic                   hostReady,
  output logic [1:0]             memWrValid,
  output logic [1:0][DATA_W-1:0] memWrData,
  input  logic [1:0]             memWrReady,
  output logic [1:0]             memRdReqValid,
  input  logic [1:0]             memRdReqReady,
  input  logic [1:0]             memRspValid,
  input  logic [1:0][DATA_W-1:0] memRspData,
  output logic                   outValid,
  output logic [2*DATA_W-1:0]    outData,
  input  logic                   outReady
);
  localparam int CW = $clog2(DEPTH + 1);

  dlsmStrobes_t       st;
  logic [1:0]         wrFull, wrEmpty, rdEmpty;
  logic [1:0][CW-1:0] rdCount;

  dlsm_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostReady(hostReady),
    .wrFull(wrFull), .wrEmpty(wrEmpty),
    .memWrReady(memWrReady), .memWrValid(memWrValid),
    .rdCount(rdCount), .rdEmpty(rdEmpty),
    .memRdReqReady(memRdReqReady), .memRdReqValid(memRdReqValid),
    .memRspValid(memRspValid),
    .outReady(outReady), .outValid(outValid),
    .st(st)
  );

  dlsm_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN),
    .st(st), .hostData(hostData), .rspData(memRspData),
    .wrData(memWrData), .outData(outData),
    .wrFull(wrFull), .wrEmpty(wrEmpty),
    .rdEmpty(rdEmpty), .rdCount(rdCount)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R7
endmodule

// File: tb/dual_lane_stream_merge_bench.sv
`timescale 1ns/1ps
module dual_lane_stream_merge_bench;
  localparam int W = 16;
  localparam int D = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN = 1'b0;
  logic              hostValid = 1'b0;
  logic [W-1:0]      hostData = '0;
  logic              hostReady;
  logic [1:0]        memWrValid;
  logic [1:0][W-1:0] memWrData;
  logic [1:0]        memWrReady = '0;
  logic [1:0]        memRdReqValid;
  logic [1:0]        memRdReqReady = '0;
  logic [1:0]        memRspValid = '0;
  logic [1:0][W-1:0] memRspData = '0;
  logic              outValid;
  logic [2*W-1:0]    outData;
  logic              outReady = 1'b0;

  dual_lane_stream_merge #(.DATA_W(W), .DEPTH(D)) u_dual_lane_stream_merge (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostData(hostData), .hostReady(hostReady),
    .memWrValid(memWrValid), .memWrData(memWrData), .memWrReady(memWrReady),
    .memRdReqValid(memRdReqValid), .memRdReqReady(memRdReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model state (ring buffers)
  logic [W-1:0] wqd [2][64];
  int wqH [2], wqN [2];
  logic [W-1:0] rqd [2][64];
  int rqH [2], rqN [2];
  int outst [2];
  int sel;
  // Memory environment
  logic [W-1:0] memd [2][4096];
  int memN [2], rdIdx [2];
  logic [W-1:0] pend [2][64];
  int pH [2], pN [2];
  int hostCnt, outIdx;
  int pHost, pWr, pReq, pRsp0, pRsp1, pOut;
  bit holdPrev;
  logic [2*W-1:0] prevData;

  function automatic logic [W-1:0] fw(input int k);
    return W'(k * 37 + 5);
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      wqH[c] = 0; wqN[c] = 0; rqH[c] = 0; rqN[c] = 0; outst[c] = 0;
      memN[c] = 0; rdIdx[c] = 0; pH[c] = 0; pN[c] = 0;
    end
    sel = 0; hostCnt = 0; outIdx = 0; holdPrev = 1'b0; prevData = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hostValid = 1'b0; memWrReady = '0; memRdReqReady = '0;
    memRspValid = '0; memRspData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    rstN = 1'b1;
    #1;
    chk(hostReady === 1'b1, "R8 hostReady after reset", 32'(hostReady), 32'd1);
    chk(outValid === 1'b0, "R8 outValid after reset", 32'(outValid), 32'd0);
    chk(memWrValid === 2'b00, "R8 memWrValid after reset", 32'(memWrValid), 32'd0);
    chk(memRdReqValid === 2'b11, "R8 memRdReqValid after reset", 32'(memRdReqValid), 32'd3);
  endtask

  task automatic step();
    bit expHR, expOV, hf, pf;
    bit [1:0] wf, rf;
    @(negedge clk);
    hostValid = ($urandom_range(99) < pHost);
    hostData  = fw(hostCnt);
    for (int c = 0; c < 2; c++) begin
      memWrReady[c]    = ($urandom_range(99) < pWr);
      memRdReqReady[c] = (rdIdx[c] < memN[c]) && ($urandom_range(99) < pReq);
      memRspValid[c]   = (pN[c] > 0) && ($urandom_range(99) < (c == 0 ? pRsp0 : pRsp1));
      memRspData[c]    = (pN[c] > 0) ? pend[c][pH[c]] : '0;
    end
    outReady = ($urandom_range(99) < pOut);
    #1;
    expHR = (wqN[sel] < D);
    chk(hostReady === expHR, "R3 hostReady", 32'(hostReady), 32'(expHR));
    for (int c = 0; c < 2; c++) begin
      chk(memWrValid[c] === (wqN[c] > 0), "R2 memWrValid", 32'(memWrValid[c]), 32'(wqN[c] > 0));
      if (wqN[c] > 0)
        chk(memWrData[c] === wqd[c][wqH[c]], "R1 memWrData lane word", 32'(memWrData[c]), 32'(wqd[c][wqH[c]]));
      chk(memRdReqValid[c] === (rqN[c] + outst[c] < D), "R4 memRdReqValid",
          32'(memRdReqValid[c]), 32'(rqN[c] + outst[c] < D));
    end
    expOV = (rqN[0] > 0) && (rqN[1] > 0);
    chk(outValid === expOV, "R5 outValid", 32'(outValid), 32'(expOV));
    if (expOV)
      chk(outData === {rqd[1][rqH[1]], rqd[0][rqH[0]]}, "R6 outData halves",
          outData, {rqd[1][rqH[1]], rqd[0][rqH[0]]});
    if (holdPrev)
      chk(outValid && (outData === prevData), "R7 hold under backpressure", outData, prevData);
    holdPrev = outValid && !outReady;
    prevData = outData;

    hf = hostValid && expHR;
    pf = expOV && outReady;
    for (int c = 0; c < 2; c++) begin
      wf[c] = memWrReady[c] && (wqN[c] > 0);
      rf[c] = memRdReqReady[c] && (rqN[c] + outst[c] < D);
    end
    if (pf) begin
      chk(outData[W-1:0] === fw(2 * outIdx) && outData[2*W-1:W] === fw(2 * outIdx + 1),
          "R6 host order", outData, {fw(2 * outIdx + 1), fw(2 * outIdx)});
      outIdx++;
      for (int c = 0; c < 2; c++) begin
        rqH[c] = (rqH[c] + 1) % 64; rqN[c]--;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (wf[c]) begin
        memd[c][memN[c]] = wqd[c][wqH[c]]; memN[c]++;
        wqH[c] = (wqH[c] + 1) % 64; wqN[c]--;
      end
      if (memRspValid[c]) begin
        rqd[c][(rqH[c] + rqN[c]) % 64] = memRspData[c]; rqN[c]++;
        outst[c]--;
        pH[c] = (pH[c] + 1) % 64; pN[c]--;
      end
      if (rf[c]) begin
        pend[c][(pH[c] + pN[c]) % 64] = memd[c][rdIdx[c]]; pN[c]++;
        rdIdx[c]++; outst[c]++;
      end
    end
    if (hf) begin
      wqd[sel][(wqH[sel] + wqN[sel]) % 64] = hostData; wqN[sel]++;
      sel ^= 1; hostCnt++;
    end
  endtask

  task automatic phase(input int n, input int h, input int w, input int q,
                       input int r0, input int r1, input int o);
    pHost = h; pWr = w; pReq = q; pRsp0 = r0; pRsp1 = r1; pOut = o;
    repeat (n) step();
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    modelReset();
    doReset();                              // R8
    phase(600, 70, 70, 70, 70, 70, 70);     // balanced traffic
    phase(400, 100, 80, 80, 80, 80, 5);     // output stall, host stalls (R3, R7)
    phase(400, 80, 90, 90, 90, 10, 90);     // channel 1 slow (R5)
    phase(200, 100, 30, 90, 90, 90, 90);    // slow write drain (R3)
    doReset();                              // mid-run reset (R8)
    phase(300, 90, 90, 90, 90, 90, 90);
    phase(300, 0, 90, 90, 90, 90, 100);     // drain
    chk(outIdx == hostCnt / 2 && outIdx > 20, "R5 drain complete", 32'(outIdx), 32'(hostCnt / 2));
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule